// File: doc/BRIEF.md
# Multi-Master Power Domain Voter

The block collects power votes for a set of power domains from several requesters: one application processor and a number of remote processors. A requester writes a one-hot or multi-bit mask to a SET register to ask for domains to be powered, or to a CLEAR register to withdraw its vote. Each domain keeps one vote bit per requester and stays powered while any vote remains. Power is switched only when the first vote appears or the last one goes. A per-domain command engine drives a power-request line to an external sequencer and waits for that sequencer's acknowledge.

Every domain owns one bit index, and that same index is used in all six readable registers. Software learns the progress of a command from that bit. DONE shows the domain can accept a command. ENABLE shows it is powered. Two status bits, one for each direction, show a command in flight. The SET and CLEAR bits also read back in a way that marks the moment a command is picked up. After power is removed, the engine holds the completion back for a settling interval. The interval is set in microseconds and turned into cycles from the clock frequency parameter.

Top module: `pd_vote_ctrl`

## Requirements
- R1: After reset every domain reads DONE=1, ENABLE=0, SET-STATUS=0 and CLEAR-STATUS=0, and every `pwr_req` bit is 0.
- R2: A write of 1 to bit d of SET (address 0) on an idle domain is accepted in the cycle it is presented. In the next cycle bit d of SET reads 0, DONE reads 0 and SET-STATUS reads 1. From the cycle after that, SET bit d reads 1 again.
- R3: An accepted power-on raises `pwr_req[d]` in the cycle after the write. Once `pwr_ack[d]` is seen high, the domain returns to idle with DONE=1, ENABLE=1 and SET-STATUS=0.
- R4: A write of 1 to bit d of CLEAR (address 1) on an idle domain makes CLEAR bit d read 1 and CLEAR-STATUS read 1 in the next cycle. CLEAR bit d reads 0 from the following cycle on.
- R5: When the last vote is withdrawn, `pwr_req[d]` drops and a wait of CLK_MHZ*STAB_US cycles follows. After that wait, the engine waits for `pwr_ack[d]` to be low before it reports DONE=1, ENABLE=0 and CLEAR-STATUS=0.
- R6: A domain keeps `pwr_req[d]` high and ENABLE=1 while any requester still holds a vote. A CLEAR from one requester while another still votes finishes with the domain still on.
- R7: A SET on a domain that is already on completes without `pwr_req[d]` ever dropping.
- R8: SET or CLEAR writes to a domain whose command is in progress (DONE=0) are ignored. This includes the writer's vote bit.
- R9: The bits of one write act on each domain independently, so several domains can be voted in a single access.
- R10: The read map is SET=0, CLEAR=1, DONE=2, ENABLE=3, SET-STATUS=4, CLEAR-STATUS=5, with bit d belonging to domain d. Read data is returned with `rsp_valid` one cycle after the read is accepted, taken from the state at acceptance. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Access accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_id | input | IDW | Requester index (vote bit) |
| req_wdata | input | 32 | Write data, bit d = domain d |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pwr_req | output | NUM_DOM | Power request to the sequencer, per domain |
| pwr_ack | input | NUM_DOM | Power acknowledge from the sequencer, per domain |

## Verification
A SET or CLEAR write changes a domain's state at the accepting edge. A read started on the next cycle therefore shows the armed state, and one started two cycles later shows the processing state. `pwr_req` follows the state with no register delay. Read data is due one cycle after acceptance. The behavioural model in the bench advances on the same edge the design does and stores the expected read word when the read is accepted. Comparisons are made on the falling edge: `pwr_req` every cycle, and read data in the cycle `rsp_valid` is due. The acknowledge is a four-cycle delayed copy of `pwr_req`, which places the end of each command a known number of cycles after it starts.

// File: rtl/pdv_pkg.sv
// Package: shared state encoding, register addresses and per-domain status
// bundle for the power domain voter.
package pdv_pkg;

    typedef enum logic [2:0] {
        DS_IDLE     = 3'd0,
        DS_ON_ARM   = 3'd1,
        DS_ON_WAIT  = 3'd2,
        DS_OFF_ARM  = 3'd3,
        DS_OFF_STAB = 3'd4,
        DS_OFF_WAIT = 3'd5
    } dom_state_t;

    localparam logic [2:0] A_SET  = 3'd0;
    localparam logic [2:0] A_CLR  = 3'd1;
    localparam logic [2:0] A_DONE = 3'd2;
    localparam logic [2:0] A_EN   = 3'd3;
    localparam logic [2:0] A_SSTA = 3'd4;
    localparam logic [2:0] A_CSTA = 3'd5;

    typedef struct packed {
        logic set_rd;
        logic clr_rd;
        logic done;
        logic en;
        logic set_sta;
        logic clr_sta;
    } dom_stat_t;

endpackage

// File: rtl/pdv_domain.sv
// Module: per-domain vote mask and command engine.
// Assumes set_req/clr_req are one-cycle write strobes for this domain.
// Strobes are honoured only while idle. The settling wait after power
// removal is STAB_CYC cycles long.
module pdv_domain #(
    parameter int NUM_REQ  = 4,
    parameter int IDW      = 2,
    parameter int STAB_CYC = 25000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_req,
    input  logic                 clr_req,
    input  logic [IDW-1:0]       req_id,
    input  logic                 pwr_ack,
    output logic                 pwr_req,
    output pdv_pkg::dom_stat_t   stat
);
    import pdv_pkg::*;

    localparam int CW = $clog2(STAB_CYC + 1);

    dom_state_t         st;
    logic [NUM_REQ-1:0] votes;
    logic               en_q;
    logic [CW-1:0]      cnt;
    logic               id_ok;

    assign id_ok = (int'(req_id) < NUM_REQ);

    // Command engine: state, vote mask, powered flag and settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= DS_IDLE;
            votes <= '0;
            en_q  <= 1'b0;
            cnt   <= '0;
        end else begin
            case (st)
                DS_IDLE: begin
                    if (set_req && id_ok) begin
                        votes[req_id] <= 1'b1;
                        st            <= DS_ON_ARM;
                    end else if (clr_req && id_ok) begin
                        votes[req_id] <= 1'b0;
                        st            <= DS_OFF_ARM;
                    end
                end
                DS_ON_ARM:  st <= DS_ON_WAIT;
                DS_ON_WAIT: begin
                    if (pwr_ack) begin
                        en_q <= 1'b1;
                        st   <= DS_IDLE;
                    end
                end
                DS_OFF_ARM: begin
                    cnt <= '0;
                    st  <= (votes != '0) ? DS_IDLE : DS_OFF_STAB;
                end
                DS_OFF_STAB: begin
                    if (cnt == CW'(STAB_CYC - 1)) st <= DS_OFF_WAIT;
                    else                          cnt <= cnt + 1'b1;
                end
                DS_OFF_WAIT: begin
                    if (!pwr_ack) begin
                        en_q <= 1'b0;
                        st   <= DS_IDLE;
                    end
                end
                default: st <= DS_IDLE;
            endcase
        end
    end

    // Power request: held during power-on, follows powered flag when idle/arming-off.
    always_comb begin
        case (st)
            DS_ON_ARM, DS_ON_WAIT:    pwr_req = 1'b1;
            DS_IDLE, DS_OFF_ARM:      pwr_req = en_q;
            default:                  pwr_req = 1'b0;
        endcase
    end

    // Status bits as seen by software.
    always_comb begin
        stat.set_rd  = (st != DS_ON_ARM);
        stat.clr_rd  = (st == DS_OFF_ARM);
        stat.done    = (st == DS_IDLE);
        stat.en      = en_q;
        stat.set_sta = (st == DS_ON_ARM) || (st == DS_ON_WAIT);
        stat.clr_sta = (st == DS_OFF_ARM) || (st == DS_OFF_STAB) || (st == DS_OFF_WAIT);
    end

    p_arm_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DS_ON_ARM) |=> (st == DS_ON_WAIT));
    p_on_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(pwr_ack));
    p_off_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> !$past(pwr_ack));
    p_held_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DS_IDLE && votes != '0 && en_q) |-> pwr_req);
    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != DS_IDLE) |=> $stable(votes));

endmodule

// File: rtl/pdv_regport.sv
// Module: register access decode. It turns writes into per-domain SET/CLEAR
// strobes and returns registered read data one cycle after a read.
// Assumes NUM_DOM <= 32.
module pdv_regport #(
    parameter int NUM_DOM = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [2:0]          req_addr,
    input  logic [31:0]         req_wdata,
    input  pdv_pkg::dom_stat_t  stat [NUM_DOM],
    output logic [NUM_DOM-1:0]  set_hit,
    output logic [NUM_DOM-1:0]  clr_hit,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata
);
    import pdv_pkg::*;

    logic [31:0] rd_mux;
    logic        wr_set, wr_clr;

    assign wr_set = req_valid && req_write && (req_addr == A_SET);
    assign wr_clr = req_valid && req_write && (req_addr == A_CLR);

    // Per-domain strobes and read bit selection.
    always_comb begin
        rd_mux = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            set_hit[d] = wr_set && req_wdata[d];
            clr_hit[d] = wr_clr && req_wdata[d];
            case (req_addr)
                A_SET:   rd_mux[d] = stat[d].set_rd;
                A_CLR:   rd_mux[d] = stat[d].clr_rd;
                A_DONE:  rd_mux[d] = stat[d].done;
                A_EN:    rd_mux[d] = stat[d].en;
                A_SSTA:  rd_mux[d] = stat[d].set_sta;
                A_CSTA:  rd_mux[d] = stat[d].clr_sta;
                default: rd_mux[d] = 1'b0;
            endcase
        end
    end

    // Read response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end

    p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: rtl/pd_vote_ctrl.sv
// Module: top of the multi-master power domain voter. It builds NUM_DOM
// domain engines behind one register port. The settling wait is
// CLK_MHZ*STAB_US cycles.
module pd_vote_ctrl #(
    parameter int NUM_DOM = 8,
    parameter int NUM_REQ = 4,
    parameter int CLK_MHZ = 250,
    parameter int STAB_US = 100,
    localparam int IDW    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [2:0]         req_addr,
    input  logic [IDW-1:0]     req_id,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_DOM-1:0] pwr_req,
    input  logic [NUM_DOM-1:0] pwr_ack
);
    import pdv_pkg::*;

    localparam int STAB_CYC = CLK_MHZ * STAB_US;

    dom_stat_t          stat [NUM_DOM];
    logic [NUM_DOM-1:0] set_hit, clr_hit;

    assign req_ready = 1'b1;

    pdv_regport #(.NUM_DOM(NUM_DOM)) u_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .stat(stat),
        .set_hit(set_hit), .clr_hit(clr_hit),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pdv_domain #(.NUM_REQ(NUM_REQ), .IDW(IDW), .STAB_CYC(STAB_CYC)) u_dom (
            .clk(clk), .rst_n(rst_n), .set_req(set_hit[d]), .clr_req(clr_hit[d]),
            .req_id(req_id), .pwr_ack(pwr_ack[d]), .pwr_req(pwr_req[d]),
            .stat(stat[d])
        );
    end

endmodule

// File: tb/pd_vote_ctrl_test.sv
module pd_vote_ctrl_test;
    localparam int ND = 4;
    localparam int NR = 4;
    localparam int STAB = 250;   // 250 MHz * 1 us

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_addr = '0;
    logic [1:0] req_id = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [ND-1:0] pwr_req, pwr_ack;
    logic [3:0] ack_sh [ND];

    int checks = 0, fails = 0, cycles = 0;
    string cur_tag = "R10", m_tag = "R10";

    // Reference model: per domain phase, vote set, powered flag, counter.
    int  m_ph [ND];     // 0 idle,1 set armed,2 powering,3 clr armed,4 settling,5 awaiting drop
    int  m_cnt [ND];
    bit  m_on [ND];
    bit  m_vote [ND][NR];
    bit  m_rsp_v = 0;
    logic [31:0] m_rsp = '0;

    pd_vote_ctrl #(.NUM_DOM(ND), .NUM_REQ(NR), .CLK_MHZ(250), .STAB_US(1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_id(req_id),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pwr_req(pwr_req), .pwr_ack(pwr_ack));

    always #2 clk = ~clk;

    for (genvar d = 0; d < ND; d++) begin : g_ack
        assign pwr_ack[d] = ack_sh[d][3];
    end

    function automatic bit exp_req(int d);
        if (m_ph[d] == 1 || m_ph[d] == 2) return 1'b1;
        if (m_ph[d] == 0 || m_ph[d] == 3) return m_on[d];
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a);
        logic [31:0] v = '0;
        for (int d = 0; d < ND; d++) begin
            case (a)
                3'd0: v[d] = (m_ph[d] != 1);
                3'd1: v[d] = (m_ph[d] == 3);
                3'd2: v[d] = (m_ph[d] == 0);
                3'd3: v[d] = m_on[d];
                3'd4: v[d] = (m_ph[d] == 1 || m_ph[d] == 2);
                3'd5: v[d] = (m_ph[d] >= 3);
                default: v[d] = 1'b0;
            endcase
        end
        return v;
    endfunction

    function automatic bit any_vote(int d);
        for (int r = 0; r < NR; r++) if (m_vote[d][r]) return 1'b1;
        return 1'b0;
    endfunction

    // Model advance on the same edge as the design.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int d = 0; d < ND; d++) begin
                m_ph[d] = 0; m_cnt[d] = 0; m_on[d] = 0;
                for (int r = 0; r < NR; r++) m_vote[d][r] = 0;
            end
            m_rsp_v = 0;
        end else begin
            m_rsp_v = req_valid && !req_write;
            m_tag = cur_tag;
            if (m_rsp_v) m_rsp = exp_read(req_addr);
            for (int d = 0; d < ND; d++) begin
                case (m_ph[d])
                    0: if (req_valid && req_write && req_wdata[d]) begin
                           if (req_addr == 3'd0) begin m_vote[d][req_id] = 1; m_ph[d] = 1; end
                           else if (req_addr == 3'd1) begin m_vote[d][req_id] = 0; m_ph[d] = 3; end
                       end
                    1: m_ph[d] = 2;
                    2: if (pwr_ack[d]) begin m_on[d] = 1; m_ph[d] = 0; end
                    3: begin m_cnt[d] = 0; m_ph[d] = any_vote(d) ? 0 : 4; end
                    4: if (m_cnt[d] == STAB - 1) m_ph[d] = 5; else m_cnt[d]++;
                    5: if (!pwr_ack[d]) begin m_on[d] = 0; m_ph[d] = 0; end
                    default: m_ph[d] = 0;
                endcase
            end
        end
    end

    // Sequencer stand-in: acknowledge is pwr_req delayed by four cycles.
    always @(negedge clk) begin
        for (int d = 0; d < ND; d++)
            ack_sh[d] <= rst_n ? {ack_sh[d][2:0], pwr_req[d]} : 4'b0;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < ND; d++)
                chk(pwr_req[d] == exp_req(d), "R3 R5 R6 R7 pwr_req", 32'(pwr_req[d]), 32'(exp_req(d)));
            chk(rsp_valid == m_rsp_v, "R10 rsp_valid", 32'(rsp_valid), 32'(m_rsp_v));
            if (m_rsp_v) chk(rsp_rdata == m_rsp, m_tag, rsp_rdata, m_rsp);
        end
    end

    task automatic wr(logic [2:0] a, int id, logic [31:0] data);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_id = 2'(id); req_wdata = data;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(logic [2:0] a, string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; cur_tag = tag;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int d = 0; d < ND; d++) ack_sh[d] = 4'b0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state of every register
        for (int a = 0; a < 6; a++) rd(3'(a), "R1");
        // R2, R3: power-on of domain 0 by requester 0
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 3'd0; req_id = 0; req_wdata = 32'h1;
        @(negedge clk);
        req_write = 0; req_addr = 3'd0; cur_tag = "R2 set reads 0";
        @(negedge clk);
        req_addr = 3'd0; cur_tag = "R2 set reads 1";
        @(negedge clk);
        req_addr = 3'd2; cur_tag = "R2 done 0";
        @(negedge clk);
        req_valid = 0;
        rd(3'd4, "R2 set-status");
        idle(8);
        rd(3'd2, "R3 done"); rd(3'd3, "R3 enable"); rd(3'd4, "R3 set-status");
        // R7: second voter on an already-on domain
        wr(3'd0, 1, 32'h1);
        idle(4);
        rd(3'd3, "R7 enable"); rd(3'd2, "R7 done");
        // R6: first voter leaves, second still holds
        wr(3'd1, 0, 32'h1);
        idle(4);
        rd(3'd3, "R6 enable"); rd(3'd5, "R6 clear-status");
        // R4, R5: last vote withdrawn
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 3'd1; req_id = 1; req_wdata = 32'h1;
        @(negedge clk);
        req_write = 0; req_addr = 3'd1; cur_tag = "R4 clear reads 1";
        @(negedge clk);
        req_addr = 3'd1; cur_tag = "R4 clear reads 0";
        @(negedge clk);
        req_addr = 3'd5; cur_tag = "R4 clear-status";
        @(negedge clk);
        req_valid = 0;
        idle(100);
        rd(3'd2, "R5 done low during settle"); rd(3'd3, "R5 enable during settle");
        idle(200);
        rd(3'd2, "R5 done"); rd(3'd3, "R5 enable"); rd(3'd5, "R5 clear-status");
        // R9, R8: two domains in one write, then a write to a busy domain
        wr(3'd0, 2, 32'h6);
        wr(3'd1, 3, 32'h2);
        idle(10);
        rd(3'd3, "R9 enable"); rd(3'd2, "R8 done");
        wr(3'd1, 2, 32'h2);   // only vote is requester 2; requester 3 had none recorded
        idle(300);
        rd(3'd3, "R8 enable after off"); rd(3'd2, "R8 done after off");
        // R10: unmapped address
        rd(3'd7, "R10 unmapped");
        idle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule